// File: doc/BRIEF.md
# Pointer Authentication Sign/Verify Unit

This block signs and checks 64-bit pointers. The low 48 bits of a pointer carry the virtual address, so the top 16 bits are free. A sign request writes a keyed 16-bit code into those free bits. An authenticate request computes the code again and compares it with the one the pointer carries. When the codes match, the code is stripped and a canonical pointer is returned. When they differ, the block returns a poisoned pointer with a pass flag of 0 and raises no fault of its own. A later translation stage sees the non-canonical pattern and rejects the pointer. The poison bits also record whether an instruction key or a data key failed.

The code is a keyed mixing function of three things: the 48-bit address, a 64-bit salt or context word, and one of five secret keys. It is not a faithful block cipher. The function is built as a four-stage pipeline that takes one request per cycle. The keys sit in a small register bank. Software writes and reads that bank through a side port, and the port works only while a privilege input is high. Each request takes its key from the bank in the cycle it is accepted.

Top module: `ptr_auth_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_ptr` and `out_pass` are 0, and all five keys read back as 0.
- R2: A request accepted with `in_valid` high at clock edge N appears with `out_valid` high after edge N+3, four cycles later. Requests may arrive on back-to-back cycles, and results leave in the same order.
- R3: The 16-bit code is computed from the inputs as follows:
  - Start with s = {16'h0, ptr[47:0]} XOR salt.
  - Apply four rounds, r = 0..3: s = rotl64(s XOR rotl64(key, 16*r), 23) + s, where the addition is modulo 2^64.
  - The code is s[63:48] ^ s[47:32] ^ s[31:16] ^ s[15:0].
- R4: Sign (`in_op_auth`=0) with a legal key returns {code, ptr[47:0]} with `out_pass`=1. Any bits that were in ptr[63:48] are discarded.
- R5: Authenticate (`in_op_auth`=1) with a legal key, where ptr[63:48] equals the code, returns {16 copies of ptr[47], ptr[47:0]} with `out_pass`=1.
- R6: Authenticate with a legal key, where the codes differ, returns the same canonical pointer as R5 but with bits [62:61] forced. They become 2'b10 for instruction keys (select 0, 1) and 2'b01 for data keys (select 2, 3). `out_pass` is 0.
- R7: Key selects 4 (generic key) and 5 to 7 are illegal for both operations. They return `in_ptr` unchanged with `out_pass`=0.
- R8: While `key_priv` is 0, a key write leaves the bank unchanged and `key_rd_data` reads 0. While `key_priv` is 1, a write to select 0 to 4 updates that key and `key_rd_data` returns the selected key. Selects 5 to 7 read 0.
- R9: A request uses the key value held in the bank at the edge that accepts it. A key write made while the request is in flight does not change its result.
- R10: While `out_valid` is 0, `out_ptr` and `out_pass` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op_auth | input | 1 | 0 = sign, 1 = authenticate |
| in_key_sel | input | 3 | 0,1 instruction keys; 2,3 data keys; 4 generic; 5-7 unused |
| in_ptr | input | 64 | Pointer operand |
| in_salt | input | 64 | Salt/context value |
| out_valid | output | 1 | Result strobe |
| out_ptr | output | 64 | Signed, stripped, poisoned or echoed pointer |
| out_pass | output | 1 | 1 = sign done or authentication matched |
| key_priv | input | 1 | Privilege qualifier for the key port |
| key_wr_en | input | 1 | Key write strobe |
| key_wr_sel | input | 3 | Key written |
| key_wr_data | input | 64 | Key write value |
| key_rd_sel | input | 3 | Key read select |
| key_rd_data | output | 64 | Key read value, 0 when unprivileged |

## Verification
Assertions check the following on every cycle:
- the four-cycle strobe latency;
- quiet outputs while idle;
- that sign keeps the address bits and passes;
- that a passing authentication is canonical;
- that a failed authentication carries the poison pattern of its key class;
- that illegal selects echo the pointer;
- that an unprivileged cycle leaves the key bank unchanged.

Only the bench scenarios can show that the code value matches the mixing definition, that a tampered code is actually caught, and that ordering holds across a dense stream. They also show that a key rewritten mid-flight does not reach an older request, and that the privilege gate holds from the read side.

// File: rtl/ptr_auth_pkg.sv
// Shared constants, the pipeline slot type and the mixing helpers.
// Assumes a 64-bit pointer with a 48-bit virtual address.
package ptr_auth_pkg;
    localparam int WORD_W   = 64;
    localparam int VA_W     = 48;
    localparam int CODE_W   = WORD_W - VA_W;
    localparam int ROUNDS   = 4;
    localparam int KEY_CNT  = 5;
    localparam int KSEL_W   = 3;
    localparam int MIX_ROT  = 23;
    localparam int KEY_STEP = CODE_W;
    localparam int POISON_LSB = 61;

    localparam logic [KSEL_W-1:0] KSEL_DATA_A = 3'd2;
    localparam logic [KSEL_W-1:0] KSEL_GEN    = 3'd4;
    localparam logic [1:0] POISON_INST = 2'b10;
    localparam logic [1:0] POISON_DATA = 2'b01;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic              vld;
        logic              auth;
        logic [KSEL_W-1:0] ksel;
        word_t             ptr;
        word_t             key;
        word_t             st;
    } pa_slot_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        int unsigned m;
        m = n % WORD_W;
        if (m == 0) return x;
        return (x << m) | (x >> (WORD_W - m));
    endfunction

    // One mixing round applied to a slot's state word.
    function automatic pa_slot_t mix_step(input pa_slot_t s, input int unsigned rnd);
        pa_slot_t o;
        o    = s;
        o.st = rotl(s.st ^ rotl(s.key, rnd * KEY_STEP), MIX_ROT) + s.st;
        return o;
    endfunction

    // Fold the final state down to the code width.
    function automatic logic [CODE_W-1:0] fold_code(input word_t s);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = 0; i < WORD_W / CODE_W; i++) c ^= s[i*CODE_W +: CODE_W];
        return c;
    endfunction
endpackage

// File: rtl/pa_key_bank.sv
// Key register bank. Writes and reads through the side port require the
// privilege input. The datapath port reads the selected key
// unconditionally and returns zero for unused selects.
module pa_key_bank
    import ptr_auth_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv,
    input  logic              wr_en,
    input  logic [KSEL_W-1:0] wr_sel,
    input  word_t             wr_data,
    input  logic [KSEL_W-1:0] rd_sel,
    output word_t             rd_data,
    input  logic [KSEL_W-1:0] use_sel,
    output word_t             use_key
);
    logic [KEY_CNT-1:0][WORD_W-1:0] keys;

    // Privileged key update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keys <= '0;
        end else if (wr_en && priv) begin
            for (int i = 0; i < KEY_CNT; i++)
                if (wr_sel == KSEL_W'(i)) keys[i] <= wr_data;
        end
    end

    // Privileged read-back mux.
    always_comb begin
        rd_data = '0;
        if (priv)
            for (int i = 0; i < KEY_CNT; i++)
                if (rd_sel == KSEL_W'(i)) rd_data = keys[i];
    end

    // Datapath key mux.
    always_comb begin
        use_key = '0;
        for (int i = 0; i < KEY_CNT; i++)
            if (use_sel == KSEL_W'(i)) use_key = keys[i];
    end

    p_locked_keys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !priv |=> $stable(keys));
endmodule

// File: rtl/pa_mix_pipe.sv
// Four-register mixing pipeline. Each stage applies one round and carries
// the request fields alongside. Assumes the caller loads the round-0 state.
module pa_mix_pipe
    import ptr_auth_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pa_slot_t in_slot,
    output pa_slot_t out_slot
);
    pa_slot_t stg [ROUNDS];

    // Advance every stage by one round per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROUNDS; i++) stg[i].vld <= 1'b0;
        end else begin
            stg[0] <= mix_step(in_slot, 0);
            for (int i = 1; i < ROUNDS; i++) stg[i] <= mix_step(stg[i-1], i);
        end
    end

    assign out_slot = stg[ROUNDS-1];

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot.vld |-> ##4 out_slot.vld);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_slot.vld |-> ##4 !out_slot.vld);
endmodule

// File: rtl/pa_result_fmt.sv
// Output formatter. From the last pipeline slot it builds the signed,
// stripped, poisoned or echoed pointer and the pass flag. Combinational only.
module pa_result_fmt
    import ptr_auth_pkg::*;
(
    input  pa_slot_t slot,
    output logic     out_valid,
    output word_t    out_ptr,
    output logic     out_pass
);
    logic [CODE_W-1:0] code;
    word_t             canon;
    word_t             poisoned;
    logic              legal;
    logic              inst_key;

    // Shared intermediate values.
    always_comb begin
        code     = fold_code(slot.st);
        canon    = {{CODE_W{slot.ptr[VA_W-1]}}, slot.ptr[VA_W-1:0]};
        legal    = slot.ksel < KSEL_GEN;
        inst_key = slot.ksel < KSEL_DATA_A;
        poisoned = canon;
        poisoned[POISON_LSB +: 2] = inst_key ? POISON_INST : POISON_DATA;
    end

    // Select the result by operation and outcome.
    always_comb begin
        out_valid = slot.vld;
        out_ptr   = '0;
        out_pass  = 1'b0;
        if (slot.vld) begin
            if (!legal) begin
                out_ptr = slot.ptr;
            end else if (!slot.auth) begin
                out_ptr  = {code, slot.ptr[VA_W-1:0]};
                out_pass = 1'b1;
            end else if (slot.ptr[WORD_W-1:VA_W] == code) begin
                out_ptr  = canon;
                out_pass = 1'b1;
            end else begin
                out_ptr = poisoned;
            end
        end
    end
endmodule

// File: rtl/ptr_auth_unit.sv
// Pointer authentication sign/verify unit top. It joins the key bank, the
// mixing pipeline and the result formatter. A request's key is taken from
// the bank at acceptance and travels with it down the pipeline.
module ptr_auth_unit
    import ptr_auth_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_op_auth,
    input  logic [2:0]  in_key_sel,
    input  logic [63:0] in_ptr,
    input  logic [63:0] in_salt,
    output logic        out_valid,
    output logic [63:0] out_ptr,
    output logic        out_pass,
    input  logic        key_priv,
    input  logic        key_wr_en,
    input  logic [2:0]  key_wr_sel,
    input  logic [63:0] key_wr_data,
    input  logic [2:0]  key_rd_sel,
    output logic [63:0] key_rd_data
);
    word_t    cur_key;
    pa_slot_t head;
    pa_slot_t tail;

    pa_key_bank bank_i (
        .clk(clk), .rst_n(rst_n), .priv(key_priv),
        .wr_en(key_wr_en), .wr_sel(key_wr_sel), .wr_data(key_wr_data),
        .rd_sel(key_rd_sel), .rd_data(key_rd_data),
        .use_sel(in_key_sel), .use_key(cur_key)
    );

    // Build the entry slot with the round-0 state.
    always_comb begin
        head.vld  = in_valid;
        head.auth = in_op_auth;
        head.ksel = in_key_sel;
        head.ptr  = in_ptr;
        head.key  = cur_key;
        head.st   = {{CODE_W{1'b0}}, in_ptr[VA_W-1:0]} ^ in_salt;
    end

    pa_mix_pipe pipe_i (.clk(clk), .rst_n(rst_n), .in_slot(head), .out_slot(tail));

    pa_result_fmt fmt_i (.slot(tail), .out_valid(out_valid), .out_ptr(out_ptr), .out_pass(out_pass));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_ptr == '0) && !out_pass);
    p_sign_keeps_va_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !tail.auth && tail.ksel < KSEL_GEN)
        |-> out_pass && (out_ptr[VA_W-1:0] == tail.ptr[VA_W-1:0]));
    p_strip_canon_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tail.auth && out_pass)
        |-> out_ptr[WORD_W-1:VA_W] == {CODE_W{out_ptr[VA_W-1]}});
    p_poison_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tail.auth && tail.ksel < KSEL_GEN && !out_pass)
        |-> out_ptr[POISON_LSB +: 2] == ((tail.ksel < KSEL_DATA_A) ? POISON_INST : POISON_DATA));
    p_illegal_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tail.ksel >= KSEL_GEN) |-> !out_pass && (out_ptr == tail.ptr));
endmodule

// File: tb/ptr_auth_unit_tb_top.sv
module ptr_auth_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_op_auth = 1'b0;
    logic [2:0]  in_key_sel = '0;
    logic [63:0] in_ptr = '0, in_salt = '0;
    logic        out_valid, out_pass;
    logic [63:0] out_ptr;
    logic        key_priv = 1'b0, key_wr_en = 1'b0;
    logic [2:0]  key_wr_sel = '0, key_rd_sel = '0;
    logic [63:0] key_wr_data = '0;
    logic [63:0] key_rd_data;

    ptr_auth_unit dut_i (.*);

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0, wr_i = 0, rd_i = 0;
    bit mon_on = 1'b0;
    logic [63:0] bk [5];
    logic [63:0] e_ptr [1024];
    logic        e_pass [1024];
    int          e_cyc [1024];
    string       e_tag [1024];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] b_rotl(input logic [63:0] x, input int n);
        logic [63:0] r;
        r = x;
        for (int i = 0; i < n; i++) r = {r[62:0], r[63]};
        return r;
    endfunction

    function automatic logic [15:0] b_code(input logic [63:0] p, input logic [63:0] s, input logic [63:0] k);
        logic [63:0] st;
        st = {16'h0, p[47:0]} ^ s;
        for (int r = 0; r < 4; r++) st = b_rotl(st ^ b_rotl(k, 16 * r), 23) + st;
        return st[63:48] ^ st[47:32] ^ st[31:16] ^ st[15:0];
    endfunction

    task automatic model(input bit auth, input logic [2:0] ks, input logic [63:0] p, input logic [63:0] s,
                         output logic [63:0] ep, output logic epass);
        logic [63:0] k, canon;
        logic [15:0] c;
        k = (ks < 5) ? bk[ks] : 64'h0;
        c = b_code(p, s, k);
        canon = {{16{p[47]}}, p[47:0]};
        if (ks >= 4) begin ep = p; epass = 0; end
        else if (!auth) begin ep = {c, p[47:0]}; epass = 1; end
        else if (p[63:48] == c) begin ep = canon; epass = 1; end
        else begin
            ep = canon;
            ep[62:61] = (ks < 2) ? 2'b10 : 2'b01;
            epass = 0;
        end
    endtask

    task automatic push(input bit auth, input logic [2:0] ks, input logic [63:0] p, input logic [63:0] s, input string tag);
        logic [63:0] ep; logic epass;
        model(auth, ks, p, s, ep, epass);
        @(negedge clk);
        in_valid = 1; in_op_auth = auth; in_key_sel = ks; in_ptr = p; in_salt = s;
        e_ptr[wr_i] = ep; e_pass[wr_i] = epass; e_cyc[wr_i] = cyc + 4; e_tag[wr_i] = tag;
        wr_i++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic wkey(input bit pv, input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        key_priv = pv; key_wr_en = 1; key_wr_sel = sel; key_wr_data = d;
        if (pv && sel < 5) bk[sel] = d;
        @(negedge clk);
        key_wr_en = 0; key_priv = 0;
    endtask

    task automatic rkey(input bit pv, input logic [2:0] sel, output logic [63:0] d);
        @(negedge clk);
        key_priv = pv; key_rd_sel = sel;
        #1 d = key_rd_data;
        key_priv = 0;
    endtask

    // Output monitor: in-order compare, latency, idle quietness.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (out_valid) begin
                if (rd_i >= wr_i) chk(0, "R2 unexpected output", out_ptr, 64'h0);
                else begin
                    chk(out_ptr == e_ptr[rd_i] && out_pass == e_pass[rd_i],
                        $sformatf("%s ptr/pass(pass=%0b exp %0b)", e_tag[rd_i], out_pass, e_pass[rd_i]),
                        out_ptr, e_ptr[rd_i]);
                    chk(cyc == e_cyc[rd_i], "R2 latency", 64'(cyc), 64'(e_cyc[rd_i]));
                    rd_i++;
                end
            end else begin
                chk(out_ptr == 64'h0 && !out_pass, "R10 idle outputs", out_ptr, 64'h0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [63:0] d, sp;
        logic ep;
        logic [63:0] ptrs [4];
        logic [63:0] salts [2];
        ptrs[0] = 64'h0000_1234_5678_9abc; ptrs[1] = 64'hdead_8000_0000_1000;
        ptrs[2] = 64'h00ff_7fff_ffff_fff8; ptrs[3] = 64'hffff_ffff_ffff_ffff;
        salts[0] = 64'h0; salts[1] = 64'h0000_7ff0_1234_0040;
        for (int i = 0; i < 5; i++) bk[i] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && out_ptr == 0 && !out_pass, "R1 outputs after reset", out_ptr, 64'h0);
        for (int i = 0; i < 5; i++) begin
            rkey(1, 3'(i), d);
            chk(d == 64'h0, "R1 key reset", d, 64'h0);
        end
        mon_on = 1;

        // R8: privileged write/read, unprivileged write and read
        for (int i = 0; i < 5; i++) wkey(1, 3'(i), 64'h9e37_79b9_7f4a_7c15 * 64'(i + 3) ^ 64'(i));
        for (int i = 0; i < 5; i++) begin
            rkey(1, 3'(i), d);
            chk(d == bk[i], "R8 privileged readback", d, bk[i]);
        end
        wkey(0, 3'd2, 64'hbad0_bad0_bad0_bad0);
        rkey(1, 3'd2, d);
        chk(d == bk[2], "R8 unprivileged write ignored", d, bk[2]);
        rkey(0, 3'd0, d);
        chk(d == 64'h0, "R8 unprivileged read zero", d, 64'h0);
        rkey(1, 3'd6, d);
        chk(d == 64'h0, "R8 unused select reads zero", d, 64'h0);

        // Dense sweep over every key select and both operations.
        for (int k = 0; k < 8; k++) begin
            for (int pi = 0; pi < 4; pi++) begin
                for (int si = 0; si < 2; si++) begin
                    push(0, 3'(k), ptrs[pi], salts[si], (k < 4) ? "R4/R3 sign" : "R7 illegal sign");
                    if (k < 4) begin
                        model(0, 3'(k), ptrs[pi], salts[si], sp, ep);
                        push(1, 3'(k), sp, salts[si], "R5/R3 auth match");
                        push(1, 3'(k), sp ^ (64'h1 << (48 + pi * 4 + si)), salts[si], "R6 auth tampered code");
                        push(1, 3'(k), sp, salts[si] ^ 64'h10, "R6 auth wrong salt");
                    end else begin
                        push(1, 3'(k), ptrs[pi], salts[si], "R7 illegal auth");
                    end
                end
            end
        end
        idle();
        repeat (6) @(negedge clk);

        // R9: key rewrite while a request is in flight
        push(0, 3'd0, ptrs[0], salts[1], "R9 old key kept in flight");
        idle();
        wkey(1, 3'd0, 64'h0f1e_2d3c_4b5a_6978);
        push(0, 3'd0, ptrs[0], salts[1], "R9 new key after write");
        idle();
        repeat (8) @(negedge clk);
        chk(rd_i == wr_i, "R2 all results delivered", 64'(rd_i), 64'(wr_i));

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule